// File: doc/BRIEF.md
# Address-Latched Cartridge Bank Mapper

This block holds the bank-switching state of a game cartridge. It sits between an 8-bit CPU bus, the pattern bus of a video chip, and the external program and pattern memories. Any CPU write that lands in the upper half of the 64 KB CPU space updates the state. The low fourteen bits of the write address become a mode word, and the low two bits of the write data become a small bank field. Most of the bank state therefore travels on the address lines, not the data lines.

From this state the block builds the physical program-memory address and the physical pattern-memory address. It also produces a write enable for a pattern RAM and a nametable mirroring select. One bit of the mode word picks between a single 32 KB program window and a 16 KB window that appears twice. The memories, the CPU and the video chip are outside the block. The installed memory sizes are powers of two, and bank numbers larger than the memory wrap back into it.

Top module: `addr_latch_mapper`

## Requirements
- R1: A cycle with `cpu_wr` high and `cpu_addr[15]` = 1 loads mode = `cpu_addr[13:0]` and bank = `cpu_data[1:0]` at that clock edge. The outputs show the new values from the following cycle on. A write with `cpu_addr[15]` = 0 changes no output.
- R2: While `rst_n` is low, mode and bank are cleared to zero. After reset, a CPU read at 0x8000 maps to program address 0, video address 0 maps to pattern address 0, and `mirror_horiz` is 0.
- R3: The 7-bit program bank number has mode bit 6 as its bit 6 and mode bits 13:8 as its bits 5:0.
- R4: When mode bit 5 is 1, the full program address is bank number × 16384 + `cpu_addr[13:0]`. The same bank is therefore seen at 0x8000–0xBFFF and at 0xC000–0xFFFF.
- R5: When mode bit 5 is 0, the full program address is (bank number >> 1) × 32768 + `cpu_addr[14:0]`.
- R6: The full pattern address is ({mode[4:0], bank[1:0]}) × 8192 + `ppu_addr[12:0]`.
- R7: `mirror_horiz` equals mode bit 7. A value of 1 selects horizontal mirroring and 0 selects vertical.
- R8: With `PAT_RAM` = 1, pattern memory is an 8 KB RAM, `chr_addr` is `ppu_addr[12:0]`, and `chr_we` follows `ppu_wr` inside the pattern range. With `PAT_RAM` = 0, `chr_we` never rises, so video writes are dropped.
- R9: Translated addresses are reduced modulo 2^`PRG_AW` bytes for program memory and modulo 2^`CHR_AW` bytes for pattern memory. Larger bank numbers alias.
- R10: `prg_sel` is 1 only for `cpu_addr` ≥ 0x8000. `chr_sel` is 1 only for `ppu_addr` < 0x2000. `chr_we` is 0 whenever `chr_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Qualified CPU write strobe, one cycle per write |
| ppu_addr | input | 14 | Video-chip pattern bus address |
| ppu_wr | input | 1 | Video-chip write strobe |
| prg_sel | output | 1 | CPU access targets program memory |
| prg_addr | output | PRG_AW | Translated program-memory byte address |
| chr_sel | output | 1 | Video access targets pattern memory |
| chr_addr | output | CHR_AW | Translated pattern-memory byte address |
| chr_we | output | 1 | Pattern RAM write enable |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
The bench aims at the boundaries of the mode word, where a shift or mask error stays hidden during ordinary use. Bank numbers that exceed the installed program memory are tested, so a design that failed to wrap would drive address bits beyond the memory. Both halves of the 16 KB window are read, so a design that passed `cpu_addr[14]` through would place the upper half in the wrong bank. In the 32 KB mode, bank 95 must land in the same place as bank 94, so a design that did not shift the bank number would be off by half a window. Writes below 0x8000 and video writes on a ROM-only build must leave the outputs and the pattern RAM unchanged. A data byte written into the 8 KB RAM must read back after the bank field changes, so a RAM build that kept the bank bits in the address would lose the byte.

// File: rtl/mapper_pkg.sv
// Package: shared widths and state type for the address-latched mapper.
// Assumes an 8-bit CPU with a 16-bit address bus and a 14-bit video bus.
package mapper_pkg;

    localparam int MODE_W      = 14;   // mode word taken from the write address
    localparam int BANK_W      = 2;    // bank field taken from the write data
    localparam int PBANK_W     = 7;    // program bank number width
    localparam int CBANK_W     = 7;    // pattern bank index width
    localparam int HALF_OFF_W  = 14;   // offset inside a 16 KB window
    localparam int FULL_OFF_W  = 15;   // offset inside a 32 KB window
    localparam int PAT_OFF_W   = 13;   // offset inside an 8 KB pattern bank
    localparam int PRG_FULL_W  = PBANK_W + HALF_OFF_W;  // 21 bits
    localparam int CHR_FULL_W  = CBANK_W + PAT_OFF_W;   // 20 bits

    // Bit positions inside the mode word that the translation decodes.
    localparam int MB_HALF     = 5;    // 1 = 16 KB program windows
    localparam int MB_PBANK_HI = 6;    // top bit of program bank number
    localparam int MB_MIRROR   = 7;    // 1 = horizontal mirroring

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [BANK_W-1:0] bank;
    } map_state_t;

    // Forms the 7-bit program bank number from the mode word.
    function automatic logic [PBANK_W-1:0] prg_bank_num(input logic [MODE_W-1:0] m);
        return {m[MB_PBANK_HI], m[13:8]};
    endfunction

endpackage

// File: rtl/bank_latch.sv
// Module: bank_latch
// Captures the mode word and bank field on a qualified CPU write into the
// upper half of CPU space. Assumes cpu_wr is high for exactly one cycle per
// bus write. Synchronous active-low reset clears both fields.
module bank_latch
    import mapper_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit,
    input  logic [MODE_W-1:0]    addr_bits,
    input  logic [BANK_W-1:0]    data_bits,
    output map_state_t           state
);

    map_state_t state_q;

    // Register update: clear on reset, load address and data on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (hit) begin
            state_q.mode <= addr_bits;
            state_q.bank <= data_bits;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/prg_xlate.sv
// Module: prg_xlate
// Combinational program-address translation. Picks a 16 KB window (seen
// twice) or one 32 KB window from the mode word, then keeps the low PRG_AW
// bits so oversize bank numbers wrap. Assumes 15 <= PRG_AW <= 21.
module prg_xlate
    import mapper_pkg::*;
#(
    parameter int PRG_AW = 17
) (
    input  map_state_t           state,
    input  logic [15:0]          cpu_addr,
    output logic                 prg_sel,
    output logic [PRG_AW-1:0]    prg_addr
);

    localparam int PRG_BYTES = 1 << PRG_AW;

    logic [PBANK_W-1:0]    bank_num;
    logic [PRG_FULL_W-1:0] full_half;
    logic [PRG_FULL_W-1:0] full_whole;
    logic [PRG_FULL_W-1:0] full_sel;

    // Bank number and the two candidate full addresses.
    always_comb begin
        bank_num   = prg_bank_num(state.mode);
        full_half  = {bank_num, cpu_addr[HALF_OFF_W-1:0]};
        full_whole = {1'b0, bank_num[PBANK_W-1:1], cpu_addr[FULL_OFF_W-1:0]};
    end

    // Window-size select from the mode word.
    always_comb begin
        if (state.mode[MB_HALF]) full_sel = full_half;
        else                     full_sel = full_whole;
    end

    // Wrap to installed size: a full-width build passes through unchanged.
    generate
        if (PRG_AW >= PRG_FULL_W) begin : g_nowrap
            assign prg_addr = PRG_AW'(full_sel);
        end else begin : g_wrap
            assign prg_addr = full_sel[PRG_AW-1:0];
        end
    endgenerate

    assign prg_sel = cpu_addr[15];

    initial begin
        if (PRG_BYTES < (1 << FULL_OFF_W))
            $display("prg_xlate: PRG_AW below 32 KB window");
    end

endmodule

// File: rtl/chr_xlate.sv
// Module: chr_xlate
// Combinational pattern-address translation and pattern RAM write enable.
// With PAT_RAM = 0 the memory is a ROM of 2^CHR_AW bytes and writes are
// dropped; with PAT_RAM = 1 it is an 8 KB RAM, so the bank bits wrap away.
// Assumes CHR_AW >= 13.
module chr_xlate
    import mapper_pkg::*;
#(
    parameter int CHR_AW  = 15,
    parameter bit PAT_RAM = 1'b0
) (
    input  map_state_t           state,
    input  logic [13:0]          ppu_addr,
    input  logic                 ppu_wr,
    output logic                 chr_sel,
    output logic [CHR_AW-1:0]    chr_addr,
    output logic                 chr_we
);

    logic [CBANK_W-1:0]    bank_idx;
    logic [CHR_FULL_W-1:0] full_addr;

    // Pattern bank index: mode low bits above the two-bit bank field.
    always_comb begin
        bank_idx  = {state.mode[4:0], state.bank};
        full_addr = {bank_idx, ppu_addr[PAT_OFF_W-1:0]};
    end

    assign chr_sel = ~ppu_addr[13];

    // Variant choice: RAM keeps only the 8 KB offset, ROM wraps at CHR_AW.
    generate
        if (PAT_RAM) begin : g_ram
            if (CHR_AW > PAT_OFF_W) begin : g_pad
                assign chr_addr = {{(CHR_AW-PAT_OFF_W){1'b0}}, ppu_addr[PAT_OFF_W-1:0]};
            end else begin : g_exact
                assign chr_addr = ppu_addr[PAT_OFF_W-1:0];
            end
            assign chr_we = ppu_wr & chr_sel;
        end else begin : g_rom
            if (CHR_AW >= CHR_FULL_W) begin : g_nowrap
                assign chr_addr = CHR_AW'(full_addr);
            end else begin : g_wrap
                assign chr_addr = full_addr[CHR_AW-1:0];
            end
            assign chr_we = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/addr_latch_mapper.sv
// Module: addr_latch_mapper (top)
// Bank-switching logic for a cartridge: snoops CPU writes at 0x8000-0xFFFF,
// latches address bits 13:0 and data bits 1:0, and translates CPU and video
// addresses into program and pattern memory addresses. Assumes memories
// are external, power-of-two sized, and that cpu_wr is a qualified strobe.
module addr_latch_mapper
    import mapper_pkg::*;
#(
    parameter int PRG_AW  = 17,
    parameter int CHR_AW  = 15,
    parameter bit PAT_RAM = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          cpu_addr,
    input  logic [7:0]           cpu_data,
    input  logic                 cpu_wr,
    input  logic [13:0]          ppu_addr,
    input  logic                 ppu_wr,
    output logic                 prg_sel,
    output logic [PRG_AW-1:0]    prg_addr,
    output logic                 chr_sel,
    output logic [CHR_AW-1:0]    chr_addr,
    output logic                 chr_we,
    output logic                 mirror_horiz
);

    map_state_t        state;
    logic              reg_hit;
    logic [MODE_W-1:0] mode_q;
    logic [BANK_W-1:0] bank_q;

    // Write qualification: only the upper half of CPU space loads state.
    assign reg_hit = cpu_wr & cpu_addr[15];

    bank_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (reg_hit),
        .addr_bits (cpu_addr[MODE_W-1:0]),
        .data_bits (cpu_data[BANK_W-1:0]),
        .state     (state)
    );

    prg_xlate #(.PRG_AW(PRG_AW)) u_prg (
        .state    (state),
        .cpu_addr (cpu_addr),
        .prg_sel  (prg_sel),
        .prg_addr (prg_addr)
    );

    chr_xlate #(.CHR_AW(CHR_AW), .PAT_RAM(PAT_RAM)) u_chr (
        .state    (state),
        .ppu_addr (ppu_addr),
        .ppu_wr   (ppu_wr),
        .chr_sel  (chr_sel),
        .chr_addr (chr_addr),
        .chr_we   (chr_we)
    );

    // Named views of the held state for the bound checker.
    assign mode_q       = state.mode;
    assign bank_q       = state.bank;
    assign mirror_horiz = state.mode[MB_MIRROR];

endmodule

// File: rtl/mapper_chk.sv
// Module: mapper_chk
// Property checker bound to addr_latch_mapper. Relates register loads to
// the bus, and the translated outputs to the held mode word.
module mapper_chk #(
    parameter int PRG_AW = 17,
    parameter int CHR_AW = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic [7:0]        cpu_data,
    input logic              cpu_wr,
    input logic [13:0]       ppu_addr,
    input logic              ppu_wr,
    input logic [13:0]       mode_q,
    input logic [1:0]        bank_q,
    input logic [PRG_AW-1:0] prg_addr,
    input logic [CHR_AW-1:0] chr_addr,
    input logic              chr_we,
    input logic              mirror_horiz
);

    a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15]) |=>
            (mode_q == $past(cpu_addr[13:0]) && bank_q == $past(cpu_data[1:0])));

    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr[15]) |=> ($stable(mode_q) && $stable(bank_q)));

    a_r7_mirror_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15]) |=> (mirror_horiz == $past(cpu_addr[7])));

    a_r4_half_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[5] && cpu_addr[15]) |-> (prg_addr[13:0] == cpu_addr[13:0]));

    a_r5_whole_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[5] && cpu_addr[15]) |-> (prg_addr[14:0] == cpu_addr[14:0]));

    a_r6_pat_offset: assert property (@(posedge clk) disable iff (!rst_n)
        !ppu_addr[13] |-> (chr_addr[12:0] == ppu_addr[12:0]));

    a_r10_no_we_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (ppu_addr[13] || !ppu_wr) |-> !chr_we);

endmodule

bind addr_latch_mapper mapper_chk #(.PRG_AW(PRG_AW), .CHR_AW(CHR_AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_addr     (cpu_addr),
    .cpu_data     (cpu_data),
    .cpu_wr       (cpu_wr),
    .ppu_addr     (ppu_addr),
    .ppu_wr       (ppu_wr),
    .mode_q       (mode_q),
    .bank_q       (bank_q),
    .prg_addr     (prg_addr),
    .chr_addr     (chr_addr),
    .chr_we       (chr_we),
    .mirror_horiz (mirror_horiz)
);

// File: tb/sim_addr_latch_mapper.sv
`timescale 1ns/100ps
// Bench: a ROM build (u0) and an 8 KB RAM build (u1) share one bus. A
// behavioural model tracks the latched state and is compared every cycle.
module sim_addr_latch_mapper;

    localparam int PRG_AW = 17;
    localparam int CHR_AW = 15;
    localparam longint PRG_SIZE = 64'd1 << PRG_AW;
    localparam longint CHR_SIZE = 64'd1 << CHR_AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_wr = 1'b0;
    logic [13:0] ppu_addr = '0;
    logic        ppu_wr = 1'b0;
    logic [7:0]  ppu_data = '0;

    logic              prg_sel0, chr_sel0, chr_we0, mir0;
    logic [PRG_AW-1:0] prg_addr0;
    logic [CHR_AW-1:0] chr_addr0;
    logic              prg_sel1, chr_sel1, chr_we1, mir1;
    logic [PRG_AW-1:0] prg_addr1;
    logic [12:0]       chr_addr1;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    int m_mode = 0;
    int m_bank = 0;
    logic [7:0] pram [8192];

    always #2.5 clk = ~clk;

    addr_latch_mapper #(.PRG_AW(PRG_AW), .CHR_AW(CHR_AW), .PAT_RAM(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .ppu_wr(ppu_wr),
        .prg_sel(prg_sel0), .prg_addr(prg_addr0), .chr_sel(chr_sel0),
        .chr_addr(chr_addr0), .chr_we(chr_we0), .mirror_horiz(mir0));

    addr_latch_mapper #(.PRG_AW(PRG_AW), .CHR_AW(13), .PAT_RAM(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .ppu_wr(ppu_wr),
        .prg_sel(prg_sel1), .prg_addr(prg_addr1), .chr_sel(chr_sel1),
        .chr_addr(chr_addr1), .chr_we(chr_we1), .mirror_horiz(mir1));

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference: state update rule for the model.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode <= 0;
            m_bank <= 0;
        end else if (cpu_wr && cpu_addr >= 16'h8000) begin
            m_mode <= int'(cpu_addr) % 16384;
            m_bank <= int'(cpu_data) % 4;
        end
    end

    // Pattern RAM modelled as a bench array written through u1.
    always @(posedge clk) begin
        if (chr_we1) pram[chr_addr1] <= ppu_data;
    end

    function automatic longint exp_prg(input int m, input int a);
        longint b7;
        longint full;
        b7 = ((m / 64) % 2) * 64 + (m / 256) % 64;
        if ((m / 32) % 2 == 1) full = b7 * 16384 + (a % 16384);
        else                   full = (b7 / 2) * 32768 + (a % 32768);
        return full % PRG_SIZE;
    endfunction

    function automatic longint exp_chr(input int m, input int b, input int a);
        longint idx;
        idx = (m % 32) * 4 + b;
        return (idx * 8192 + (a % 8192)) % CHR_SIZE;
    endfunction

    // Per-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R10 prg_sel", prg_sel0, (cpu_addr >= 16'h8000) ? 1 : 0);
            chk("R10 chr_sel", chr_sel0, (ppu_addr < 14'h2000) ? 1 : 0);
            if (cpu_addr >= 16'h8000) begin
                if ((m_mode / 32) % 2 == 1)
                    chk("R4 prg_addr 16K", prg_addr0, exp_prg(m_mode, int'(cpu_addr)));
                else
                    chk("R5 prg_addr 32K", prg_addr0, exp_prg(m_mode, int'(cpu_addr)));
                chk("R4 R5 ram build prg_addr", prg_addr1, exp_prg(m_mode, int'(cpu_addr)));
            end
            if (ppu_addr < 14'h2000) begin
                chk("R6 chr_addr", chr_addr0, exp_chr(m_mode, m_bank, int'(ppu_addr)));
                chk("R8 ram chr_addr", chr_addr1, int'(ppu_addr) % 8192);
            end
            chk("R8 rom chr_we", chr_we0, 0);
            chk("R8 ram chr_we", chr_we1, (ppu_wr && ppu_addr < 14'h2000) ? 1 : 0);
            chk("R7 mirror", mir0, (m_mode / 128) % 2);
        end
    end

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1; ppu_wr = 1'b0;
        @(posedge clk); #1;
        cpu_wr = 1'b0;
    endtask

    task automatic probe(input logic [15:0] ca, input logic [13:0] pa);
        cpu_addr = ca; ppu_addr = pa; cpu_wr = 1'b0; ppu_wr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state seen at the ports.
        probe(16'h8000, 14'h0000);
        chk("R2 reset prg_addr", prg_addr0, 0);
        chk("R2 reset chr_addr", chr_addr0, 0);
        chk("R2 reset mirror", mir0, 0);
        cmp_on = 1'b1;

        // R3 R4 R9: mode 0x3F25 -> bank 63, 16K windows, wraps to 0x1C000.
        cpu_write(16'hFF25, 8'h02);
        probe(16'h8123, 14'h0010);
        chk("R4 R9 low window", prg_addr0, 17'h1C123);
        probe(16'hC123, 14'h0010);
        chk("R4 high window alias", prg_addr0, 17'h1C123);
        chk("R6 chr bank", chr_addr0, (5 * 4 + 2) * 8192 % 32768 + 16);
        chk("R7 mirror vertical", mir0, 0);

        // R3 R5: mode 0x1F40 -> bank 95, 32K bank 47 wraps to 3.
        cpu_write(16'h9F40, 8'hFF);
        probe(16'hC001, 14'h0123);
        chk("R5 R3 32K bank", prg_addr0, 17'h1C001);
        chk("R6 bank field", chr_addr0, 15'h6123);
        cpu_write(16'h9E40, 8'h03);
        probe(16'hC001, 14'h0123);
        chk("R5 odd/even bank alias", prg_addr0, 17'h1C001);

        // R7: bit 7 set -> horizontal.
        cpu_write(16'h8080, 8'h00);
        probe(16'h8000, 14'h0000);
        chk("R7 mirror horizontal", mir0, 1);

        // R1: writes below 0x8000 are ignored.
        cpu_write(16'h7FFF, 8'h03);
        probe(16'h8005, 14'h0005);
        chk("R1 ignore low write mirror", mir0, 1);
        chk("R1 ignore low write prg", prg_addr0, 5);
        chk("R1 ignore low write chr", chr_addr0, 5);

        // R8: RAM byte survives a bank change; ROM build drops the write.
        @(posedge clk); #1;
        ppu_addr = 14'h0456; ppu_data = 8'h5A; ppu_wr = 1'b1;
        @(posedge clk); #1;
        ppu_wr = 1'b0;
        cpu_write(16'h801F, 8'h01);
        probe(16'h8000, 14'h0456);
        chk("R8 ram readback", pram[chr_addr1], 8'h5A);
        chk("R8 rom no write enable", chr_we0, 0);

        // R10: video write above pattern range never enables RAM.
        @(posedge clk); #1;
        ppu_addr = 14'h2456; ppu_data = 8'hC3; ppu_wr = 1'b1;
        @(negedge clk);
        chk("R10 we outside range", chr_we1, 0);
        @(posedge clk); #1;
        ppu_wr = 1'b0;
        probe(16'h8000, 14'h0456);
        chk("R10 ram untouched", pram[chr_addr1], 8'h5A);

        // Mixed traffic, compared every cycle by the model.
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            cpu_addr = 16'($urandom);
            cpu_data = 8'($urandom);
            cpu_wr   = ($urandom % 3) == 0;
            ppu_addr = 14'($urandom);
            ppu_data = 8'($urandom);
            ppu_wr   = ($urandom % 4) == 0;
        end
        @(posedge clk); #1;
        cpu_wr = 1'b0; ppu_wr = 1'b0;
        @(negedge clk);
        cmp_on = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule